// File: doc/BRIEF.md
# Dependency Barrier Issue Scoreboard

This block is the in-order issue gate of a statically scheduled core. The compiler resolves every hazard ahead of time, and each instruction arrives with a small control field. That field holds a fixed stall count, a yield flag, two barrier selectors (one for the result write and one for the operand read) and a bitmask of the barriers the instruction must wait on. The gate holds the instruction at the head of the stream until two conditions are met: every barrier in its mask has drained, and the stall delay set by the previous issue has run out. When the instruction issues, the gate arms the barriers it names.

Variable-latency units such as memory and shared resources return completions on a set of release ports. Each completion names one barrier. Every barrier is a saturating counter, so several outstanding operations can share one barrier. A barrier counts as clear only when its counter is zero. The block makes no register-tag comparison. Opcode decode, the register file and operand reuse are handled elsewhere.

Top module: `dbar_issue_gate`

## Requirements
- R1: After reset every barrier is clear and the stall timer is idle, so `in_ready` is high whatever the wait mask is, and `issue` and `yield_pulse` are low while `in_valid` is low.
- R2: `issue` equals `in_valid && in_ready`. `in_ready` is low in any cycle in which a barrier selected by a set bit of `in_wait` (bit b selects barrier b, for b in 0..5) has a non-zero count.
- R3: When an instruction issues, a write selector or read selector with a value in 0..5 adds one to that barrier's count. If both selectors name the same barrier, that barrier gains two.
- R4: Selector values 6 and 7 arm nothing. An instruction that issues with only such selectors leaves every barrier clear.
- R5: Each release port with its valid bit high and an index in 0..5 subtracts one from that barrier. Indices 6 and 7 are ignored, and a count never drops below zero.
- R6: An arm and a release of the same barrier in one cycle leave its count unchanged. A release becomes visible to the wait check only in the cycle after it is presented.
- R7: After an issue whose 4-bit stall field is s ≥ 1, `in_ready` stays low for the next s−1 cycles. The next issue can happen no earlier than s cycles after this one.
- R8: A stall field of 0 behaves like 1, so back-to-back issue on consecutive cycles is allowed and at most one instruction issues per cycle.
- R9: `yield_pulse` is high for exactly the cycles in which an instruction issues with its yield bit set. The yield bit has no other effect.
- R10: A barrier count saturates at its maximum (7 with the default 3-bit counter). Further arms are lost, so after saturation the same number of releases as the maximum clears the barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction at the head of the stream is present |
| in_ready | output | 1 | Gate allows issue this cycle (wait and stall both satisfied) |
| in_stall | input | 4 | Fixed stall cycles before the next issue (0 treated as 1) |
| in_yield | input | 1 | Yield flag of the instruction |
| in_wr_bar | input | 3 | Barrier armed for the result write (6, 7 = none) |
| in_rd_bar | input | 3 | Barrier armed for the operand read (6, 7 = none) |
| in_wait | input | 6 | Barriers that must be clear before issue |
| rel_valid | input | 2 | Per release port: a completion is present |
| rel_bar | input | 6 | Per release port a 3-bit barrier index, port p at bits [3p+2:3p] |
| issue | output | 1 | The instruction issues this cycle |
| yield_pulse | output | 1 | An instruction with its yield bit issues this cycle |

## Verification
Assertions check on every cycle that issue never happens while a waited barrier is pending or the stall timer is busy. They also check the counter rules: a count only rises after an arm, an equal arm and release leave it unchanged, it holds at its maximum, and the timer runs the right length after each issue. Other behaviours show only in the bench's scenarios, where a reference model tracks the counts and the timer. These are the one-cycle delay before a release becomes visible, the ignored selector and index values 6 and 7, the double arm when both selectors name the same barrier, the recovery after saturation, and the yield pulse under random traffic.

// File: rtl/dbar_pkg.sv
// Package: shared sizes and helpers for the dependency barrier issue gate.
// Assumes: barrier indices are binary encoded; any index >= NUM_BAR is "none".
package dbar_pkg;
    localparam int NUM_BAR  = 6;   // number of dependency barriers
    localparam int IDX_W    = 3;   // width of a barrier selector
    localparam int STALL_W  = 4;   // width of the stall-cycle field
    localparam int CNT_W    = 3;   // width of one barrier counter
    localparam int NUM_REL  = 2;   // number of release (completion) ports

    // Cycles to hold the timer after an issue: a zero field behaves as one.
    function automatic logic [STALL_W-1:0] hold_after(input logic [STALL_W-1:0] s);
        return (s == '0) ? '0 : s - STALL_W'(1);
    endfunction
endpackage

// File: rtl/dbar_counter.sv
// Module: one saturating barrier counter.
// Adds inc and subtracts dec in one step, then clamps to 0..2^CNT_W-1.
// Assumes: inc and dec are already decoded for this barrier.
module dbar_counter #(
    parameter int CNT_W = dbar_pkg::CNT_W,
    parameter int INC_W = 2,
    parameter int DEC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic [DEC_W-1:0] dec,
    output logic             busy
);
    localparam int MAXC = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cnt;
    int               nxt_i;
    logic             seen;

    // Net change, clamped to the counter range.
    always_comb begin
        nxt_i = int'(cnt) + int'(inc) - int'(dec);
        if (nxt_i < 0)
            nxt_i = 0;
        else if (nxt_i > MAXC)
            nxt_i = MAXC;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= CNT_W'(nxt_i);
    end

    // Marks that one post-reset cycle has been sampled (for $past checks).
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= 1'b0;
        else
            seen <= 1'b1;
    end

    assign busy = (cnt != '0);

    a_r3_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (cnt > $past(cnt)) |-> ($past(inc) != '0));

    a_r6_balanced_hold: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (int'($past(inc)) == int'($past(dec))) |-> (cnt == $past(cnt)));

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        ($past(cnt) == CNT_W'(MAXC) && $past(dec) == '0) |-> (cnt == CNT_W'(MAXC)));

    a_r5_fall_needs_release: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (cnt < $past(cnt)) |-> ($past(dec) != '0));
endmodule

// File: rtl/dbar_bank.sv
// Module: the bank of barrier counters.
// Decodes the arm selectors of an issuing instruction and the release ports
// into a per-barrier increment and decrement, and reports which barriers are pending.
// Assumes: selector or index values >= NUM_BAR name no barrier.
module dbar_bank #(
    parameter int NUM_BAR = dbar_pkg::NUM_BAR,
    parameter int IDX_W   = dbar_pkg::IDX_W,
    parameter int CNT_W   = dbar_pkg::CNT_W,
    parameter int NUM_REL = dbar_pkg::NUM_REL
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arm_en,
    input  logic [IDX_W-1:0]         arm_wr,
    input  logic [IDX_W-1:0]         arm_rd,
    input  logic [NUM_REL-1:0]       rel_valid,
    input  logic [NUM_REL*IDX_W-1:0] rel_bar,
    output logic [NUM_BAR-1:0]       bar_busy
);
    localparam int DEC_W = $clog2(NUM_REL + 1);

    for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar
        logic [1:0]       inc;
        logic [DEC_W-1:0] dec;
        int               dsum;

        // Arm count for this barrier from both selectors.
        always_comb begin
            inc = {1'b0, (arm_en && arm_wr == IDX_W'(b))}
                + {1'b0, (arm_en && arm_rd == IDX_W'(b))};
        end

        // Number of release ports naming this barrier this cycle.
        always_comb begin
            dsum = 0;
            for (int p = 0; p < NUM_REL; p++) begin
                if (rel_valid[p] && rel_bar[p*IDX_W +: IDX_W] == IDX_W'(b))
                    dsum = dsum + 1;
            end
            dec = DEC_W'(dsum);
        end

        dbar_counter #(
            .CNT_W (CNT_W),
            .INC_W (2),
            .DEC_W (DEC_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc),
            .dec   (dec),
            .busy  (bar_busy[b])
        );
    end
endmodule

// File: rtl/dbar_stall_timer.sv
// Module: fixed-latency stall countdown.
// On issue loads (stall field - 1), treating 0 as 1, and counts down to zero.
// busy blocks the next issue while the count is non-zero.
module dbar_stall_timer #(
    parameter int STALL_W = dbar_pkg::STALL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [STALL_W-1:0] stall_in,
    output logic               busy
);
    logic [STALL_W-1:0] left;
    logic               seen;

    // Load on issue, otherwise count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (fire)
            left <= dbar_pkg::hold_after(stall_in);
        else if (left != '0)
            left <= left - STALL_W'(1);
    end

    // Marks that one post-reset cycle has been sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= 1'b0;
        else
            seen <= 1'b1;
    end

    assign busy = (left != '0);

    a_r7_hold_after_issue: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        ($past(fire) && $past(stall_in) > STALL_W'(1)) |-> busy);

    a_r8_short_stall_free: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        ($past(fire) && $past(stall_in) <= STALL_W'(1)) |-> !busy);

    a_r7_no_fire_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fire);
endmodule

// File: rtl/dbar_issue_gate.sv
// Module: top of the dependency barrier issue gate.
// Combines the wait-mask check against the barrier bank with the stall timer
// to form in_ready, issues on valid && ready, arms barriers and pulses yield.
// Assumes: one instruction is offered at a time, in program order.
module dbar_issue_gate #(
    parameter int NUM_BAR = dbar_pkg::NUM_BAR,
    parameter int IDX_W   = dbar_pkg::IDX_W,
    parameter int STALL_W = dbar_pkg::STALL_W,
    parameter int CNT_W   = dbar_pkg::CNT_W,
    parameter int NUM_REL = dbar_pkg::NUM_REL
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [STALL_W-1:0]       in_stall,
    input  logic                     in_yield,
    input  logic [IDX_W-1:0]         in_wr_bar,
    input  logic [IDX_W-1:0]         in_rd_bar,
    input  logic [NUM_BAR-1:0]       in_wait,
    input  logic [NUM_REL-1:0]       rel_valid,
    input  logic [NUM_REL*IDX_W-1:0] rel_bar,
    output logic                     issue,
    output logic                     yield_pulse
);
    logic [NUM_BAR-1:0] bar_busy;
    logic               stall_busy;
    logic               wait_block;

    // Wait check and issue decision.
    always_comb begin
        wait_block  = ((in_wait & bar_busy) != '0);
        in_ready    = !stall_busy && !wait_block;
        issue       = in_valid && in_ready;
        yield_pulse = issue && in_yield;
    end

    dbar_bank #(
        .NUM_BAR (NUM_BAR),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W),
        .NUM_REL (NUM_REL)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_en    (issue),
        .arm_wr    (in_wr_bar),
        .arm_rd    (in_rd_bar),
        .rel_valid (rel_valid),
        .rel_bar   (rel_bar),
        .bar_busy  (bar_busy)
    );

    dbar_stall_timer #(
        .STALL_W (STALL_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (issue),
        .stall_in (in_stall),
        .busy     (stall_busy)
    );

    a_r2_wait_respected: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> ((in_wait & bar_busy) == '0));

    a_r8_timer_respected: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !stall_busy);

    a_r9_yield_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        yield_pulse |-> (in_valid && in_yield));
endmodule

// File: tb/tb_dbar_issue_gate.sv
`timescale 1ns/1ps
module tb_dbar_issue_gate;
    localparam int NB   = 6;
    localparam int MAXC = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_stall = '0;
    logic       in_yield = 1'b0;
    logic [2:0] in_wr_bar = 3'd7;
    logic [2:0] in_rd_bar = 3'd7;
    logic [5:0] in_wait = '0;
    logic [1:0] rel_valid = '0;
    logic [5:0] rel_bar = '0;
    logic       issue;
    logic       yield_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_cnt [NB];
    int m_left;

    always #2.5 clk = ~clk;

    dbar_issue_gate dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_stall(in_stall), .in_yield(in_yield), .in_wr_bar(in_wr_bar),
        .in_rd_bar(in_rd_bar), .in_wait(in_wait), .rel_valid(rel_valid),
        .rel_bar(rel_bar), .issue(issue), .yield_pulse(yield_pulse)
    );

    function automatic bit exp_ready(input logic [5:0] w);
        bit blk = 0;
        for (int b = 0; b < NB; b++)
            if (w[b] && m_cnt[b] != 0) blk = 1;
        return (m_left == 0) && !blk;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Update the reference model at the clock edge from the driven inputs.
    task automatic model_edge();
        bit is;
        is = in_valid && exp_ready(in_wait);
        for (int b = 0; b < NB; b++) begin
            int n;
            n = m_cnt[b];
            if (is && int'(in_wr_bar) == b) n++;
            if (is && int'(in_rd_bar) == b) n++;
            for (int p = 0; p < 2; p++)
                if (rel_valid[p] && int'(rel_bar[p*3 +: 3]) == b) n--;
            if (n < 0) n = 0;
            if (n > MAXC) n = MAXC;
            m_cnt[b] = n;
        end
        if (is) m_left = (in_stall == 0) ? 0 : int'(in_stall) - 1;
        else if (m_left > 0) m_left--;
    endtask

    // Drive one cycle at the falling edge, check outputs, advance the model.
    task automatic step(input string req, input bit v, input int st, input bit y,
                        input int wr, input int rd, input int w,
                        input bit r0v, input int r0, input bit r1v, input int r1);
        bit er;
        @(negedge clk);
        in_valid = v; in_stall = 4'(st); in_yield = y;
        in_wr_bar = 3'(wr); in_rd_bar = 3'(rd); in_wait = 6'(w);
        rel_valid = {r1v, r0v}; rel_bar = {3'(r1), 3'(r0)};
        #1;
        er = exp_ready(in_wait);
        check(req, "in_ready", int'(in_ready), int'(er));
        check(req, "issue", int'(issue), int'(v && er));
        check(req, "yield_pulse", int'(yield_pulse), int'(v && er && y));
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("R2", 0, 0, 0, 7, 7, 0, 0, 7, 0, 7);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int b = 0; b < NB; b++) m_cnt[b] = 0;
        m_left = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state, all barriers clear under a full wait mask
        step("R1", 0, 0, 0, 7, 7, 6'h3F, 0, 7, 0, 7);
        // R3: arm barrier 2, then a waiter is blocked
        step("R3", 1, 0, 0, 2, 7, 0, 0, 7, 0, 7);
        step("R3", 1, 0, 0, 7, 7, 6'h04, 0, 7, 0, 7);
        // R6: release presented in the same cycle does not unblock yet
        step("R6", 1, 0, 0, 7, 7, 6'h04, 1, 2, 0, 7);
        step("R6", 1, 0, 0, 7, 7, 6'h04, 0, 7, 0, 7);
        // R4: selectors 6 and 7 arm nothing
        step("R4", 1, 0, 0, 6, 7, 0, 0, 7, 0, 7);
        step("R4", 1, 0, 0, 7, 6, 6'h3F, 0, 7, 0, 7);
        // R3: both selectors on barrier 1 give a count of two
        step("R3", 1, 0, 0, 1, 1, 0, 0, 7, 0, 7);
        step("R3", 0, 0, 0, 7, 7, 6'h02, 1, 1, 0, 7);
        step("R3", 0, 0, 0, 7, 7, 6'h02, 0, 7, 0, 7);
        step("R3", 0, 0, 0, 7, 7, 6'h02, 1, 1, 0, 7);
        step("R3", 0, 0, 0, 7, 7, 6'h02, 0, 7, 0, 7);
        // R5: index 7 ignored, release at zero does not underflow
        step("R5", 0, 0, 0, 7, 7, 0, 1, 7, 1, 4);
        step("R5", 1, 0, 0, 4, 7, 0, 0, 7, 0, 7);
        step("R5", 0, 0, 0, 7, 7, 6'h10, 0, 7, 0, 7);
        step("R5", 0, 0, 0, 7, 7, 6'h10, 1, 4, 0, 7);
        step("R5", 0, 0, 0, 7, 7, 6'h10, 0, 7, 0, 7);
        // R6: arm and release of barrier 3 together keep its count
        step("R6", 1, 0, 0, 3, 7, 0, 0, 7, 0, 7);
        step("R6", 1, 0, 0, 3, 7, 0, 1, 3, 0, 7);
        step("R6", 0, 0, 0, 7, 7, 6'h08, 1, 3, 0, 7);
        step("R6", 0, 0, 0, 7, 7, 6'h08, 0, 7, 0, 7);
        // R7: stall 4 blocks three cycles
        step("R7", 1, 4, 0, 7, 7, 0, 0, 7, 0, 7);
        for (int i = 0; i < 4; i++) step("R7", 1, 0, 0, 7, 7, 0, 0, 7, 0, 7);
        // R8: stall 0 and 1 allow back-to-back issue
        for (int i = 0; i < 3; i++) step("R8", 1, i % 2, 0, 7, 7, 0, 0, 7, 0, 7);
        // R9: yield pulses only on issue
        step("R9", 1, 3, 1, 7, 7, 0, 0, 7, 0, 7);
        step("R9", 1, 0, 1, 7, 7, 0, 0, 7, 0, 7);
        idle(2);
        step("R9", 1, 0, 1, 7, 7, 0, 0, 7, 0, 7);
        // R10: saturate barrier 0 with ten arms, then seven releases clear it
        for (int i = 0; i < 5; i++) step("R10", 1, 0, 0, 0, 0, 0, 0, 7, 0, 7);
        for (int i = 0; i < 3; i++) step("R10", 0, 0, 0, 7, 7, 6'h01, 1, 0, 1, 0);
        step("R10", 0, 0, 0, 7, 7, 6'h01, 1, 0, 0, 7);
        step("R10", 0, 0, 0, 7, 7, 6'h01, 0, 7, 0, 7);

        // R2: constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            step("R2", ($urandom % 4) != 0, ($urandom % 3 == 0) ? int'($urandom % 16) : int'($urandom % 3),
                 ($urandom % 5) == 0, int'($urandom % 8), int'($urandom % 8),
                 int'($urandom & $urandom & 32'h3F),
                 ($urandom % 2) == 1, int'($urandom % 8), ($urandom % 3) == 0, int'($urandom % 8));
        end
        finish_run();
    end
endmodule